// File: doc/BRIEF.md
# LED Row Refresh and Brightness Sequencer

This block drives a multiplexed LED dot matrix of 8 rows by 20 columns. It steps through the rows one at a time. For the selected row it turns on the column drivers whose stored dot bit is set. The dot pattern reaches the block as a flat latch vector. The block takes its settings from two control words that another block writes: a brightness and power word, and a word that holds the oscillator prescale bit. It has no software access of its own.

Time is counted in display cycles. A display cycle is a single-clock enable pulse, taken from one of two sources:
- the internal oscillator's tick, or
- the external oscillator's tick, optionally divided by eight.

Each row owns a slot of 64 display cycles, so a full frame takes 512 display cycles. The last four cycles of every slot are always dark. Brightness is set by a 4-bit code. The code picks how many cycles, counted from the start of the slot, the row stays lit. The spacing of these values is nonlinear. A separate 2-bit field selects the peak drive current. The block turns that field into an ascending level rank for the analog current sources.

A power-down bit freezes the scan and turns every driver off. An external blanking input darkens the columns without disturbing the scan.

Top module: `led_scan_sequencer`

## Requirements
- R1: Each display tick advances the slot cycle counter (0..63). The tick taken at cycle 63 returns it to 0 and advances the row (0..7). Row 7 wraps to row 0. After reset both counters are 0.
- R2: While the slot cycle is 60 or above, every column enable is 0.
- R3: Bits [3:0] of control word 0 hold the brightness code. Codes 0..15 give a lit length of 0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60 cycles. A column may be on only while the slot cycle is below that length.
- R4: While awake, `row_sel` is one-hot with bit r set for current row r. `col_en[c]` follows `dot_latch[c*8 + r]` inside the lit window.
- R5: While `blank` is 1, all column enables are 0 and the row scan continues unchanged.
- R6: While control word 0 bit 6 is 0 (asleep), `row_sel` and `col_en` are all 0. The row and cycle counters and the prescaler hold their values, and scanning resumes from the held position on waking.
- R7: With `osc_internal` = 1, each `int_tick` pulse is one display tick, whatever the prescale bit.
- R8: With `osc_internal` = 0, each `ext_tick` pulse is one display tick when `ext_div8` = 0. When `ext_div8` = 1, a 3-bit prescaler counts `ext_tick` pulses from reset and issues one display tick on every eighth pulse.
- R9: `peak_rank` maps control word 0 bits [5:4] to an ascending rank: 10→0 (31%), 01→1 (50%), 00→2 (73%), 11→3 (100%).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| dot_latch | input | 160 | Latched dot pattern, 8 bits per column, bit offset = row |
| ctrl0 | input | 7 | Control word 0: [6] awake, [5:4] peak current, [3:0] brightness code |
| ext_div8 | input | 1 | Prescale bit from control word 1 |
| blank | input | 1 | Forces all columns dark when 1 |
| osc_internal | input | 1 | 1 selects the internal tick, 0 the external tick |
| int_tick | input | 1 | Internal oscillator enable pulse |
| ext_tick | input | 1 | External oscillator enable pulse |
| row_sel | output | 8 | One-hot row drive |
| col_en | output | 20 | Column drive enables |
| peak_rank | output | 2 | Peak current rank, 0 lowest to 3 highest |

## Verification
The hardest state to reach is a divided external source interleaved with sleep and source switching. In that case the prescaler phase, the held scan position and the lit window all have to line up after waking.

The stimulus gets there in two ways:
- A long directed run with the external tick held high and the divider on crosses several row boundaries.
- Randomized stretches then change source, prescale, sleep and blanking every few dozen cycles, with sparse ticks.

A port-level model that is updated tick by tick predicts every row and column on every cycle.

// File: rtl/scan_pkg.sv
package scan_pkg;

   typedef enum logic [1:0] {
      PK_R31  = 2'd0,
      PK_R50  = 2'd1,
      PK_R73  = 2'd2,
      PK_R100 = 2'd3
   } peak_rank_e;

   // Lit length in display cycles for each brightness code
   function automatic logic [5:0] lit_cycles(input logic [3:0] code);
      logic [5:0] n;
      case (code)
         4'd0:  n = 6'd0;
         4'd1:  n = 6'd1;
         4'd2:  n = 6'd2;
         4'd3:  n = 6'd3;
         4'd4:  n = 6'd4;
         4'd5:  n = 6'd5;
         4'd6:  n = 6'd7;
         4'd7:  n = 6'd9;
         4'd8:  n = 6'd11;
         4'd9:  n = 6'd14;
         4'd10: n = 6'd18;
         4'd11: n = 6'd22;
         4'd12: n = 6'd28;
         4'd13: n = 6'd36;
         4'd14: n = 6'd48;
         default: n = 6'd60;
      endcase
      return n;
   endfunction

   // Current field to ascending rank
   function automatic peak_rank_e rank_of(input logic [1:0] fld);
      peak_rank_e r;
      case (fld)
         2'b10:   r = PK_R31;
         2'b01:   r = PK_R50;
         2'b00:   r = PK_R73;
         default: r = PK_R100;
      endcase
      return r;
   endfunction

endpackage

// File: rtl/scan_tick_gen.sv
module scan_tick_gen #(
   parameter int unsigned PRESCALE = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic awake,
   input  logic use_int,
   input  logic div_on,
   input  logic int_tick,
   input  logic ext_tick,
   output logic disp_tick
);

   logic ext_path;

   generate
      if (PRESCALE > 1) begin : g_div
         localparam int unsigned PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);

         logic [PS_W-1:0] ps_cnt;
         logic            ps_adv;

         assign ps_adv = awake & ~use_int & div_on & ext_tick;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               ps_cnt <= '0;
            end else if (ps_adv) begin
               ps_cnt <= (ps_cnt == PS_LAST) ? '0 : ps_cnt + 1'b1;
            end
         end

         assign ext_path = div_on ? (ext_tick & (ps_cnt == PS_LAST)) : ext_tick;

         // R8: a divided tick is never followed at once by another divided tick
         a_r8_div_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            (disp_tick && !use_int && div_on) |=> (use_int || !div_on || !disp_tick));
      end else begin : g_nodiv
         assign ext_path = ext_tick;
      end
   endgenerate

   assign disp_tick = awake & (use_int ? int_tick : ext_path);

endmodule

// File: rtl/scan_slot_ctr.sv
module scan_slot_ctr #(
   parameter int unsigned ROWS     = 8,
   parameter int unsigned SLOT_CYC = 64,
   localparam int unsigned RW      = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int unsigned CW      = $clog2(SLOT_CYC)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          tick,
   output logic [RW-1:0] row_idx,
   output logic [CW-1:0] cyc_idx
);

   localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);
   localparam logic [CW-1:0] CYC_LAST = CW'(SLOT_CYC - 1);

   logic slot_end;
   assign slot_end = (cyc_idx == CYC_LAST);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cyc_idx <= '0;
         row_idx <= '0;
      end else if (tick) begin
         cyc_idx <= slot_end ? '0 : cyc_idx + 1'b1;
         if (slot_end) begin
            row_idx <= (row_idx == ROW_LAST) ? '0 : row_idx + 1'b1;
         end
      end
   end

   // R1: slot boundary moves to the next row
   a_r1_slot_wrap: assert property (@(posedge clk) disable iff (!rst_n)
      (tick && cyc_idx == CYC_LAST) |=>
         (cyc_idx == '0 && row_idx == (($past(row_idx) == ROW_LAST) ? '0 : $past(row_idx) + 1'b1)));

   // R1: within a slot the row is held
   a_r1_row_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (cyc_idx != CYC_LAST) |=> $stable(row_idx));

   // R6: without a tick the scan position does not move
   a_r6_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      !tick |=> ($stable(cyc_idx) && $stable(row_idx)));

endmodule

// File: rtl/scan_col_drive.sv
module scan_col_drive #(
   parameter int unsigned COLS  = 20,
   parameter int unsigned ROWS  = 8,
   localparam int unsigned RW   = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int unsigned DOTW = COLS * ROWS
) (
   input  logic [DOTW-1:0] dots,
   input  logic [RW-1:0]   row_idx,
   input  logic            lit,
   output logic [COLS-1:0] col_en
);

   generate
      for (genvar c = 0; c < COLS; c++) begin : g_col
         logic [ROWS-1:0] grp;
         assign grp       = dots[c*ROWS +: ROWS];
         assign col_en[c] = lit & grp[row_idx];
      end
   endgenerate

endmodule

// File: rtl/led_scan_sequencer.sv
module led_scan_sequencer #(
   parameter int unsigned COLS       = 20,
   parameter int unsigned ROWS       = 8,
   parameter int unsigned SLOT_CYC   = 64,
   parameter int unsigned TAIL_DARK  = 4,
   parameter int unsigned PRESCALE   = 8,
   localparam int unsigned DOTW      = COLS * ROWS,
   localparam int unsigned RW        = (ROWS > 1) ? $clog2(ROWS) : 1,
   localparam int unsigned CW        = $clog2(SLOT_CYC)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [DOTW-1:0] dot_latch,
   input  logic [6:0]      ctrl0,
   input  logic            ext_div8,
   input  logic            blank,
   input  logic            osc_internal,
   input  logic            int_tick,
   input  logic            ext_tick,
   output logic [ROWS-1:0] row_sel,
   output logic [COLS-1:0] col_en,
   output logic [1:0]      peak_rank
);
   import scan_pkg::*;

   localparam int unsigned LIT_MAX = SLOT_CYC - TAIL_DARK;

   initial begin
      assert (SLOT_CYC > TAIL_DARK) else $error("slot must exceed dark tail");
      assert ((1 << CW) == SLOT_CYC) else $error("slot length must be a power of two");
      assert (COLS > 0 && ROWS > 1) else $error("matrix too small");
   end

   logic          awake;
   logic          disp_tick;
   logic [RW-1:0] row_idx;
   logic [CW-1:0] cyc_idx;
   logic          in_window;
   logic          lit;

   assign awake = ctrl0[6];

   scan_tick_gen #(.PRESCALE(PRESCALE)) tick_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .awake     (awake),
      .use_int   (osc_internal),
      .div_on    (ext_div8),
      .int_tick  (int_tick),
      .ext_tick  (ext_tick),
      .disp_tick (disp_tick)
   );

   scan_slot_ctr #(.ROWS(ROWS), .SLOT_CYC(SLOT_CYC)) ctr_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick    (disp_tick),
      .row_idx (row_idx),
      .cyc_idx (cyc_idx)
   );

   assign in_window = (int'(cyc_idx) < int'(lit_cycles(ctrl0[3:0])))
                    && (int'(cyc_idx) < int'(LIT_MAX));
   assign lit       = awake & ~blank & in_window;

   scan_col_drive #(.COLS(COLS), .ROWS(ROWS)) drv_i (
      .dots    (dot_latch),
      .row_idx (row_idx),
      .lit     (lit),
      .col_en  (col_en)
   );

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         assign row_sel[r] = awake && (row_idx == RW'(r));
      end
   endgenerate

   assign peak_rank = rank_of(ctrl0[5:4]);

   // R2: tail of every slot is dark
   a_r2_tail_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(cyc_idx) >= int'(LIT_MAX)) |-> (col_en == '0));

   // R5: blanking darkens all columns
   a_r5_blank_dark: assert property (@(posedge clk) disable iff (!rst_n)
      blank |-> (col_en == '0));

   // R6: asleep means every driver off
   a_r6_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
      !awake |-> (row_sel == '0 && col_en == '0));

   // R4: exactly one row driven while awake
   a_r4_row_onehot: assert property (@(posedge clk) disable iff (!rst_n)
      awake |-> ($countones(row_sel) == 1));

   // R3: code 0 never lights anything
   a_r3_code0_dark: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl0[3:0] == 4'd0) |-> (col_en == '0));

endmodule

// File: tb/led_scan_sequencer_tb_top.sv
`timescale 1ns/1ps
module led_scan_sequencer_tb_top;

   localparam int COLS = 20;
   localparam int ROWS = 8;
   localparam int DOTW = COLS * ROWS;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [DOTW-1:0] dot_latch = '0;
   logic [6:0]      ctrl0 = 7'h40;
   logic            ext_div8 = 1'b0;
   logic            blank = 1'b0;
   logic            osc_internal = 1'b1;
   logic            int_tick = 1'b0;
   logic            ext_tick = 1'b0;
   logic [ROWS-1:0] row_sel;
   logic [COLS-1:0] col_en;
   logic [1:0]      peak_rank;

   // values to apply at the next falling edge
   logic [DOTW-1:0] n_dot = '0;
   logic [6:0]      n_ctrl0 = 7'h40;
   logic            n_div8 = 1'b0;
   logic            n_blank = 1'b0;
   logic            n_int = 1'b1;
   logic            n_itk = 1'b0;
   logic            n_etk = 1'b0;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   // bench model of scan position
   int m_cyc = 0;
   int m_row = 0;
   int m_ps  = 0;
   bit in_reset = 1;

   always #5 clk = ~clk;

   led_scan_sequencer dut_i (
      .clk(clk), .rst_n(rst_n), .dot_latch(dot_latch), .ctrl0(ctrl0),
      .ext_div8(ext_div8), .blank(blank), .osc_internal(osc_internal),
      .int_tick(int_tick), .ext_tick(ext_tick),
      .row_sel(row_sel), .col_en(col_en), .peak_rank(peak_rank)
   );

   function automatic int lit_len(input logic [3:0] code);
      int t[16] = '{0,1,2,3,4,5,7,9,11,14,18,22,28,36,48,60};
      return t[code];
   endfunction

   function automatic logic [1:0] exp_rank(input logic [1:0] f);
      case (f)
         2'b10: return 2'd0;
         2'b01: return 2'd1;
         2'b00: return 2'd2;
         default: return 2'd3;
      endcase
   endfunction

   function automatic logic [ROWS-1:0] exp_rows();
      logic [ROWS-1:0] v = '0;
      if (ctrl0[6]) v[m_row] = 1'b1;
      return v;
   endfunction

   function automatic logic [COLS-1:0] exp_cols();
      logic [COLS-1:0] v = '0;
      bit on = ctrl0[6] && !blank && m_cyc < 60 && m_cyc < lit_len(ctrl0[3:0]);
      for (int c = 0; c < COLS; c++) v[c] = on && dot_latch[c*ROWS + m_row];
      return v;
   endfunction

   task automatic check_now(input string tag);
      logic [ROWS-1:0] er = exp_rows();
      logic [COLS-1:0] ec = exp_cols();
      logic [1:0]      ek = exp_rank(ctrl0[5:4]);
      checks++;
      if (row_sel !== er) begin
         errors++;
         $display("FAIL %s R4/R6 row_sel act=%h exp=%h (row %0d cyc %0d)", tag, row_sel, er, m_row, m_cyc);
      end
      checks++;
      if (col_en !== ec) begin
         errors++;
         $display("FAIL %s R2/R3/R4/R5 col_en act=%h exp=%h (row %0d cyc %0d)", tag, col_en, ec, m_row, m_cyc);
      end
      checks++;
      if (peak_rank !== ek) begin
         errors++;
         $display("FAIL %s R9 peak_rank act=%0d exp=%0d", tag, peak_rank, ek);
      end
   endtask

   // one clock: apply inputs at the falling edge, check, then advance model at the rising edge
   task automatic step(input string tag);
      bit tk;
      @(negedge clk);
      dot_latch = n_dot; ctrl0 = n_ctrl0; ext_div8 = n_div8; blank = n_blank;
      osc_internal = n_int; int_tick = n_itk; ext_tick = n_etk;
      #1;
      if (!in_reset) check_now(tag);
      @(posedge clk);
      if (!in_reset && ctrl0[6]) begin
         if (osc_internal) tk = int_tick;                       // R7
         else if (!ext_div8) tk = ext_tick;                     // R8
         else begin                                             // R8 divided
            tk = ext_tick && (m_ps == 7);
            if (ext_tick) m_ps = (m_ps + 1) % 8;
         end
         if (tk) begin                                          // R1
            if (m_cyc == 63) begin
               m_cyc = 0;
               m_row = (m_row + 1) % ROWS;
            end else m_cyc++;
         end
      end
   endtask

   function automatic logic [DOTW-1:0] rnd_dots();
      logic [DOTW-1:0] v;
      for (int i = 0; i < DOTW; i += 32) v[i +: 32] = $urandom;
      return v;
   endfunction

   initial begin : watchdog
      #1500000;
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired");
         $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin : main
      void'($urandom(32'h5eed1234));
      n_dot = '1;
      n_ctrl0 = 7'h4F;
      repeat (3) step("reset");
      @(negedge clk);
      rst_n = 1'b1;
      in_reset = 0;

      // R10 / R1: reset state, row 0 cycle 0, first rows all lit
      step("after_reset");

      // R1 R2 R3 R4: internal tick every cycle, full brightness, all dots set
      n_int = 1; n_itk = 1;
      for (int i = 0; i < 600; i++) step("full_scan");

      // R3: each brightness code across a slot with a checker dot pattern
      n_dot = {5{32'hA5C3_3C5A}};
      for (int code = 0; code < 16; code++) begin
         n_ctrl0 = {1'b1, 2'b00, 4'(code)};
         for (int i = 0; i < 64; i++) step("pwm_table");
      end

      // R5: blank high for a stretch while scan continues
      n_blank = 1;
      for (int i = 0; i < 80; i++) step("blank");
      n_blank = 0;

      // R6: sleep freezes and darkens, then resumes
      n_ctrl0 = 7'h0F;
      for (int i = 0; i < 40; i++) step("sleep");
      n_ctrl0 = 7'h4F;
      for (int i = 0; i < 70; i++) step("wake");

      // R8: external source divided by eight, ext tick always high
      n_int = 0; n_div8 = 1; n_etk = 1; n_itk = 0;
      for (int i = 0; i < 1100; i++) step("ext_div8");

      // R8 undivided, R7 prescale ignored on internal
      n_div8 = 0;
      for (int i = 0; i < 200; i++) step("ext_direct");
      n_int = 1; n_div8 = 1; n_itk = 1; n_etk = 0;
      for (int i = 0; i < 200; i++) step("int_with_div");

      // R9: every current field value
      for (int f = 0; f < 4; f++) begin
         n_ctrl0 = {1'b1, 2'(f), 4'hF};
         step("peak");
      end

      // mixed random stretches over all modes
      for (int blk = 0; blk < 80; blk++) begin
         n_int   = $urandom_range(1, 0);
         n_div8  = $urandom_range(1, 0);
         n_ctrl0 = {($urandom_range(9, 0) != 0), 6'($urandom)};
         if (blk % 4 == 0) n_dot = rnd_dots();
         for (int i = 0; i < 50; i++) begin
            n_itk   = ($urandom_range(3, 0) != 0);
            n_etk   = ($urandom_range(3, 0) != 0);
            n_blank = ($urandom_range(9, 0) == 0);
            step("random");
         end
      end

      done = 1;
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule